// File: doc/BRIEF.md
# Tiled Convolver Partial-Sum Aligner

When a large convolution window is split across several convolver tiles, every tile produces a partial sum that is only meaningful once it is lined up in time with the partial sums of its neighbours. This block does that alignment and the combining add for one tile. It takes two inputs. The first is the tile's own local convolver sum. The second is the partial sum arriving on the expansion chain from the upstream tile. Each input passes through its own programmable delay. The local sum can also be scaled by 256, which is used when the tile processes the upper byte of a wide pixel. The block adds the two aligned values and sends the total down the expansion chain through a fixed four-step output pipeline.

All storage moves only on clocks where the pixel-enable input is high. A clock with the enable low is a pause, not a step. Software loads a five-bit configuration word through a simple write strobe. A synchronous reset clears the configuration, every delay stage and the output pipeline.

Top module: `tile_sum_align`

## Requirements
- R1: A synchronous reset (`rst` high at a clock edge) clears the configuration to all zeros, clears every delay stage and output stage, and leaves `exp_out` at zero. After reset, positions in a delay line that have not yet been filled read as zero.
- R2: Configuration bits [1:0] form a code that sets the local-sum delay in enabled steps: code 0 gives 0, code 1 gives 4, code 2 gives 8 and code 3 gives 12.
- R3: Configuration bit 2, when set, adds 16 enabled steps to the local-sum delay chosen by R2, giving a maximum of 28.
- R4: Configuration bit 3, when set, delays the expansion input by 4 enabled steps. When it is clear, the expansion input has no added delay.
- R5: Configuration bit 4, when set, shifts the sign-extended local sum left by 8 bit positions before the add. The low 8 bits of the shifted value are zero.
- R6: The sum formed from inputs sampled at enabled step n appears on `exp_out` after enabled step n+3. This is a latency of 4 enabled steps, counting the sampling edge.
- R7: The add is two's-complement. `local_sum` is sign-extended to ACC_W bits (32 by default, never less than 30), and the result wraps modulo 2^ACC_W.
- R8: On a clock where `pix_en` is low, no delay or output stage changes, and `exp_out` holds its value.
- R9: A configuration write with `cfg_we` high takes effect at the next clock edge. A configuration change does not clear the contents of any delay line, so a newly selected delay immediately reads history captured under the previous setting.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst | input | 1 | Synchronous reset, active high |
| pix_en | input | 1 | Pixel enable; when high, delay lines and pipeline advance |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_wdata | input | 5 | Configuration word: [1:0] local delay code, [2] local +16, [3] expansion +4, [4] local ×256 |
| local_sum | input | LOC_W (24) | Signed local convolver sum |
| exp_in | input | ACC_W (32) | Signed partial sum from the upstream tile |
| exp_out | output | ACC_W (32) | Signed combined partial sum to the downstream tile |

## Verification
All 32 configuration words are applied in sequence without a reset between them. Each word is driven with one of three input patterns. A slow ramp makes any wrong delay tap show up as a fixed offset. Full-scale alternating extremes make sign-extension and wrap-around errors visible, and distinguish a shift of the local path from a shift of the expansion path. Pseudo-random data catches bit-level mixing between the paths. Pause cycles are mixed into the stream to show that nothing advances while the enable is low. Because configurations change without a reset, the checks also show whether delay-line history survives a configuration change. A reset in the middle of the run, followed by a long local delay, shows that old history is cleared.

// File: rtl/tile_align_pkg.sv
package tile_align_pkg;

    localparam int CFG_W      = 5;
    localparam int LCL_STEP   = 4;
    localparam int LCL_BIG    = 16;
    localparam int LCL_DEPTH  = 3 * LCL_STEP + LCL_BIG;
    localparam int EXP_ADD    = 4;
    localparam int PIPE_LAT   = 4;
    localparam int HI_SHIFT   = 8;

    // Packed so that the write word maps straight onto the fields:
    // bit4 hi_byte, bit3 exp_add4, bit2 lcl_add16, bits1:0 lcl_code.
    typedef struct packed {
        logic       hi_byte;
        logic       exp_add4;
        logic       lcl_add16;
        logic [1:0] lcl_code;
    } align_cfg_t;

endpackage

// File: rtl/align_cfg_reg.sv
module align_cfg_reg
    import tile_align_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             we,
    input  logic [CFG_W-1:0] wdata,
    output align_cfg_t       cfg
);

    always_ff @(posedge clk) begin
        if (rst) begin
            cfg <= '0;
        end else if (we) begin
            cfg <= align_cfg_t'(wdata);
        end
    end

endmodule

// File: rtl/tap_delay.sv
module tap_delay #(
    parameter int W     = 24,
    parameter int DEPTH = 28,
    localparam int SELW = $clog2(DEPTH + 1)
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            en,
    input  logic [W-1:0]    d,
    input  logic [SELW-1:0] sel,
    output logic [W-1:0]    q
);

    logic [W-1:0] stg [DEPTH];

    for (genvar i = 0; i < DEPTH; i++) begin : g_stage
        if (i == 0) begin : g_head
            always_ff @(posedge clk) begin
                if (rst)     stg[i] <= '0;
                else if (en) stg[i] <= d;
            end
        end else begin : g_body
            always_ff @(posedge clk) begin
                if (rst)     stg[i] <= '0;
                else if (en) stg[i] <= stg[i-1];
            end
        end
    end

    // sel 0 passes the input through; sel k reads the stage k steps back.
    always_comb begin
        q = d;
        for (int i = 0; i < DEPTH; i++) begin
            if (int'(sel) == i + 1) q = stg[i];
        end
    end

endmodule

// File: rtl/sum_pipe.sv
module sum_pipe #(
    parameter int W      = 32,
    parameter int STAGES = 4
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         en,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);

    logic [W-1:0] stg [STAGES];

    for (genvar i = 0; i < STAGES; i++) begin : g_pipe
        if (i == 0) begin : g_first
            always_ff @(posedge clk) begin
                if (rst)     stg[i] <= '0;
                else if (en) stg[i] <= d;
            end
        end else begin : g_next
            always_ff @(posedge clk) begin
                if (rst)     stg[i] <= '0;
                else if (en) stg[i] <= stg[i-1];
            end
        end
    end

    assign q = stg[STAGES-1];

endmodule

// File: rtl/tile_sum_align.sv
module tile_sum_align
    import tile_align_pkg::*;
#(
    parameter int LOC_W = 24,
    parameter int ACC_W = 32
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             pix_en,
    input  logic             cfg_we,
    input  logic [CFG_W-1:0] cfg_wdata,
    input  logic [LOC_W-1:0] local_sum,
    input  logic [ACC_W-1:0] exp_in,
    output logic [ACC_W-1:0] exp_out
);

    localparam int LSW = $clog2(LCL_DEPTH + 1);
    localparam int ESW = $clog2(EXP_ADD + 1);

    if (ACC_W < 30) begin : g_bad_width
        $error("ACC_W must be at least 30");
    end
    if (LOC_W > ACC_W) begin : g_bad_loc
        $error("LOC_W must not exceed ACC_W");
    end

    align_cfg_t       cfg_q;
    logic [LSW-1:0]   lcl_sel;
    logic [ESW-1:0]   exp_sel;
    logic [LOC_W-1:0] lcl_dly;
    logic [ACC_W-1:0] exp_dly;
    logic [ACC_W-1:0] lcl_ext;
    logic [ACC_W-1:0] lcl_shifted;
    logic [ACC_W-1:0] sum_d;

    align_cfg_reg u_cfg (
        .clk   (clk),
        .rst   (rst),
        .we    (cfg_we),
        .wdata (cfg_wdata),
        .cfg   (cfg_q)
    );

    always_comb begin
        lcl_sel = LSW'(cfg_q.lcl_code) * LSW'(LCL_STEP);
        if (cfg_q.lcl_add16) lcl_sel = lcl_sel + LSW'(LCL_BIG);
        exp_sel = cfg_q.exp_add4 ? ESW'(EXP_ADD) : '0;
    end

    // Local path is stored at its native width, before sign extension.
    tap_delay #(.W(LOC_W), .DEPTH(LCL_DEPTH)) u_lcl_dly (
        .clk (clk),
        .rst (rst),
        .en  (pix_en),
        .d   (local_sum),
        .sel (lcl_sel),
        .q   (lcl_dly)
    );

    tap_delay #(.W(ACC_W), .DEPTH(EXP_ADD)) u_exp_dly (
        .clk (clk),
        .rst (rst),
        .en  (pix_en),
        .d   (exp_in),
        .sel (exp_sel),
        .q   (exp_dly)
    );

    always_comb begin
        lcl_ext     = {{(ACC_W-LOC_W){lcl_dly[LOC_W-1]}}, lcl_dly};
        lcl_shifted = cfg_q.hi_byte ? (lcl_ext << HI_SHIFT) : lcl_ext;
        sum_d       = lcl_shifted + exp_dly;
    end

    sum_pipe #(.W(ACC_W), .STAGES(PIPE_LAT)) u_out (
        .clk (clk),
        .rst (rst),
        .en  (pix_en),
        .d   (sum_d),
        .q   (exp_out)
    );

endmodule

// File: rtl/tile_sum_align_chk.sv
module tile_sum_align_chk
    import tile_align_pkg::*;
#(
    parameter int ACC_W = 32
) (
    input logic             clk,
    input logic             rst,
    input logic             pix_en,
    input logic             cfg_we,
    input logic [CFG_W-1:0] cfg_wdata,
    input logic [ACC_W-1:0] exp_in,
    input logic [ACC_W-1:0] exp_out,
    input logic [CFG_W-1:0] cfg_q,
    input logic [ACC_W-1:0] exp_dly,
    input logic [ACC_W-1:0] lcl_shifted
);

    // Consecutive enabled, non-reset edges seen so far (saturating).
    logic [2:0] run_cnt;
    always_ff @(posedge clk) begin
        if (rst || !pix_en) run_cnt <= '0;
        else if (run_cnt != 3'd7) run_cnt <= run_cnt + 3'd1;
    end

    a_r1_reset_clears: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (exp_out == '0 && cfg_q == '0));

    a_r8_pause_holds: assert property (@(posedge clk) disable iff (rst)
        !pix_en |=> $stable(exp_out));

    a_r9_cfg_next_edge: assert property (@(posedge clk) disable iff (rst)
        cfg_we |=> cfg_q == $past(cfg_wdata));

    a_r4_exp_four_back: assert property (@(posedge clk) disable iff (rst)
        (run_cnt >= 3'd4 && cfg_q[3]) |-> exp_dly == $past(exp_in, 4));

    a_r5_low_byte_zero: assert property (@(posedge clk) disable iff (rst)
        cfg_q[4] |-> lcl_shifted[HI_SHIFT-1:0] == '0);

endmodule

bind tile_sum_align tile_sum_align_chk #(.ACC_W(ACC_W)) u_chk (
    .clk         (clk),
    .rst         (rst),
    .pix_en      (pix_en),
    .cfg_we      (cfg_we),
    .cfg_wdata   (cfg_wdata),
    .exp_in      (exp_in),
    .exp_out     (exp_out),
    .cfg_q       (cfg_q),
    .exp_dly     (exp_dly),
    .lcl_shifted (lcl_shifted)
);

// File: tb/test_tile_sum_align.sv
module test_tile_sum_align;

    localparam int LW = 24;
    localparam int AW = 32;
    localparam int HN = 4096;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          pix_en = 1'b0;
    logic          cfg_we = 1'b0;
    logic [4:0]    cfg_wdata = '0;
    logic [LW-1:0] local_sum = '0;
    logic [AW-1:0] exp_in = '0;
    logic [AW-1:0] exp_out;

    tile_sum_align #(.LOC_W(LW), .ACC_W(AW)) i_tile_sum_align (
        .clk       (clk),
        .rst       (rst),
        .pix_en    (pix_en),
        .cfg_we    (cfg_we),
        .cfg_wdata (cfg_wdata),
        .local_sum (local_sum),
        .exp_in    (exp_in),
        .exp_out   (exp_out)
    );

    always #2.5 clk = ~clk;

    int            n_chk = 0;
    int            n_fail = 0;
    bit            done = 1'b0;
    int            k = 0;
    int            chk_from = 0;
    logic [4:0]    cur_cfg = '0;
    logic [AW-1:0] last_out = '0;
    logic [LW-1:0] hist_l [HN];
    logic [AW-1:0] hist_e [HN];
    logic [31:0]   lfsr = 32'h1234_5678;

    task automatic chk(input string tag, input logic [AW-1:0] act, input logic [AW-1:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h (cfg=%b step=%0d)", tag, act, exp, cur_cfg, k);
        end
    endtask

    // Model from the requirements: delays R2/R3/R4, shift R5, latency R6, wrap R7.
    function automatic logic [AW-1:0] expv(input int j);
        int dl = 4 * int'(cur_cfg[1:0]) + (cur_cfg[2] ? 16 : 0);
        int de = cur_cfg[3] ? 4 : 0;
        logic [LW-1:0] l = (j - dl >= 0) ? hist_l[j - dl] : '0;
        logic [AW-1:0] e = (j - de >= 0) ? hist_e[j - de] : '0;
        logic [AW-1:0] x = {{(AW-LW){l[LW-1]}}, l};
        if (cur_cfg[4]) x = x << 8;
        return x + e;
    endfunction

    function automatic logic [31:0] next_rand(input logic [31:0] s);
        logic [31:0] t = s;
        t = t ^ (t << 13);
        t = t ^ (t >> 17);
        t = t ^ (t << 5);
        return t;
    endfunction

    task automatic step(input bit en, input logic [LW-1:0] l, input logic [AW-1:0] e, input string tag);
        pix_en    = en;
        local_sum = l;
        exp_in    = e;
        if (en) begin
            hist_l[k] = l;
            hist_e[k] = e;
        end
        @(posedge clk);
        @(negedge clk);
        if (en) begin
            if (k >= chk_from) chk(tag, exp_out, expv(k - 3));
            k++;
        end else begin
            chk("R8 pause", exp_out, last_out);
        end
        last_out = exp_out;
    endtask

    task automatic write_cfg(input logic [4:0] v);
        pix_en    = 1'b0;
        cfg_we    = 1'b1;
        cfg_wdata = v;
        @(posedge clk);
        @(negedge clk);
        cfg_we   = 1'b0;
        cur_cfg  = v;
        chk_from = k + 3;
        chk("R8 cfg-idle", exp_out, last_out);
        last_out = exp_out;
    endtask

    task automatic do_reset();
        rst    = 1'b1;
        pix_en = 1'b0;
        cfg_we = 1'b0;
        repeat (2) @(posedge clk);
        @(negedge clk);
        rst      = 1'b0;
        k        = 0;
        cur_cfg  = '0;
        chk_from = 0;
        last_out = '0;
    endtask

    initial begin : watchdog
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: run did not complete");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin : main
        @(negedge clk);
        do_reset();
        chk("R1 reset output", exp_out, '0);

        // R2 R3 R4 R5 R6 R7 R9: sweep every configuration, no reset between.
        for (int c = 0; c < 32; c++) begin
            string tag;
            write_cfg(5'(c));
            tag = $sformatf("R6 R9%s%s%s%s", " R2",
                            cur_cfg[2] ? " R3" : "", cur_cfg[3] ? " R4" : "",
                            cur_cfg[4] ? " R5 R7" : " R7");
            for (int s = 0; s < 44; s++) begin
                logic [LW-1:0] l;
                logic [AW-1:0] e;
                case (c % 3)
                    0: begin
                        l = LW'(k * 3 - 50);
                        e = AW'(k * 1000 - 7);
                    end
                    1: begin
                        l = (k % 2 == 0) ? {1'b0, {(LW-1){1'b1}}} : {1'b1, {(LW-1){1'b0}}};
                        e = (k % 3 == 0) ? {1'b0, {(AW-1){1'b1}}} : {1'b1, {(AW-1){1'b0}}};
                    end
                    default: begin
                        lfsr = next_rand(lfsr);
                        l = lfsr[LW-1:0];
                        lfsr = next_rand(lfsr);
                        e = lfsr;
                    end
                endcase
                if (s % 7 == 5) step(1'b0, ~l, ~e, "R8");
                step(1'b1, l, e, tag);
            end
        end

        // R1: reset mid-stream clears config and history.
        do_reset();
        for (int s = 0; s < 6; s++) step(1'b1, LW'(s + 1), AW'(100 * s), "R1 cfg cleared");
        do_reset();
        write_cfg(5'b00111);  // local delay 28
        chk_from = 0;
        for (int s = 0; s < 36; s++) step(1'b1, LW'(s + 9), '0, "R1 history cleared R3");

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule